// File: doc/BRIEF.md
# Pointer Version Tag Checker

This block stands between a load/store source and a memory port and checks each access against a version tag. A pointer is 64 bits wide. Its top four bits hold a version number from 0 to 15. The remaining bits are the real byte address. A small tag store held in registers keeps one 4-bit version for each 64-byte memory line. For every request, the block clears the version bits to form the address, reads the stored version of the addressed line and compares it with the pointer's version in the same cycle. A match goes on to the memory port with no added wait state. A mismatch is consumed and dropped, and a fault record reports the address and both version values. This catches stale pointers and overruns into lines that carry a different version.

Privileged software sets line versions through a separate tag-write command. A global enable turns the check off, and then every request is forwarded.

Requests use valid/ready on both sides. A forwarded request reflects the downstream `mem_ready` back as `req_ready`, so back-pressure passes straight through. A blocked request is taken at once, whatever the state of `mem_ready`. A request that collides with a tag write to its own line is held, with `req_ready` low, until that write has landed. While `req_valid` is high and `req_ready` is low, the source must hold the request steady.

Top module: `ptag_guard`

## Requirements
- R1: After reset every stored line version is 0 and `fault_valid` is low, so a request whose pointer has version 0 is forwarded to the memory port.
- R2: `mem_addr` equals the pointer with bits [63:60] forced to zero. `mem_write` and `mem_wdata` equal the request's write flag and write data.
- R3: A matching request drives `mem_valid` high in the same cycle as `req_valid`, and `req_ready` follows `mem_ready` while it is forwarded.
- R4: A mismatching request keeps `mem_valid` low and is accepted at once (`req_ready` high). In the next cycle `fault_valid` is high, `fault_addr` holds the masked address, `fault_ptr_ver` holds the pointer's version and `fault_line_ver` holds the line's stored version.
- R5: A tag write stores `tagw_ver` for the line selected by `tagw_addr` bits [9:6] (16 lines of 64 bytes by default). Requests see the new version from the next cycle on.
- R6: When a request and a tag write select the same line in the same cycle, the request is neither forwarded nor faulted, and `req_ready` is low. In the following cycle the request is checked against the newly written version.
- R7: With `chk_en` low every request is forwarded whatever its version, and no fault is raised.
- R8: A tag write to a different line does not stall a request in the same cycle.
- R9: Address bits [5:0] do not select a line. Every byte of a 64-byte line shares one tag, and the next line has its own tag.
- R10: `fault_valid` lasts a single cycle for each blocked request and is low in any cycle that does not follow a blocked request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Check enable; low forwards everything |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_ptr | input | 64 | Tagged pointer (version in [63:60]) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data |
| mem_valid | output | 1 | Downstream request valid |
| mem_ready | input | 1 | Downstream ready |
| mem_addr | output | 64 | Masked byte address |
| mem_write | output | 1 | Downstream store flag |
| mem_wdata | output | 32 | Downstream store data |
| tagw_valid | input | 1 | Tag-write command valid |
| tagw_addr | input | 64 | Address inside the line to program |
| tagw_ver | input | 4 | Version to store |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_addr | output | 64 | Masked address of the blocked request |
| fault_ptr_ver | output | 4 | Version carried by the pointer |
| fault_line_ver | output | 4 | Version stored for the line |

## Verification
Forwarding, `req_ready`, the masked address and the hold on a same-line collision are combinational, so they are due in the same cycle as the request. The bench drives at a falling edge and samples one nanosecond later. A tag write takes effect at the next rising edge, and a fault record appears one rising edge after the blocked request. The bench therefore checks those results at the following falling edge, and checks that the pulse has dropped one falling edge after that. Each scenario task keeps a model of the line versions in the bench and works out its expected values from that model.

// File: rtl/ptag_pkg.sv
package ptag_pkg;
  // Outcome of the check for the request present this cycle
  typedef enum logic [1:0] {
    VD_IDLE  = 2'd0,
    VD_PASS  = 2'd1,
    VD_HOLD  = 2'd2,
    VD_BLOCK = 2'd3
  } verdict_e;
endpackage

// File: rtl/ptag_addr_split.sv
module ptag_addr_split #(
  parameter int ADDR_W = 64,
  parameter int VER_W  = 4,
  parameter int OFS_W  = 6,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] ptr,
  output logic [VER_W-1:0]  ver,
  output logic [ADDR_W-1:0] masked,
  output logic [IDX_W-1:0]  idx
);
  localparam int PLAIN_W = ADDR_W - VER_W;

  // version lives in the top bits; the rest is the real byte address
  assign ver    = ptr[ADDR_W-1 -: VER_W];
  assign masked = {{VER_W{1'b0}}, ptr[PLAIN_W-1:0]};
  // line index sits just above the byte offset
  assign idx    = masked[OFS_W +: IDX_W];
endmodule

// File: rtl/ptag_store.sv
module ptag_store #(
  parameter int VER_W     = 4,
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VER_W-1:0] wr_ver,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VER_W-1:0] rd_ver
);
  logic [VER_W-1:0] ver_q [NUM_LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) ver_q[i] <= '0;
    end else if (wr_en) begin
      ver_q[wr_idx] <= wr_ver;
    end
  end

  assign rd_ver = ver_q[rd_idx];

  AST_TAG_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ver_q[$past(wr_idx)] == $past(wr_ver))); // R5
endmodule

// File: rtl/ptag_judge.sv
module ptag_judge
  import ptag_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int VER_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic              req_valid,
  input  logic              mem_ready,
  input  logic              hazard,
  input  logic [VER_W-1:0]  ptr_ver,
  input  logic [VER_W-1:0]  line_ver,
  input  logic [ADDR_W-1:0] masked,
  output verdict_e          verdict,
  output logic              fwd_valid,
  output logic              acc_ready,
  output logic              fault_valid,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [VER_W-1:0]  fault_ptr_ver,
  output logic [VER_W-1:0]  fault_line_ver
);
  logic mismatch;
  assign mismatch = (ptr_ver != line_ver);

  always_comb begin
    if (!req_valid)                 verdict = VD_IDLE;
    else if (!chk_en)               verdict = VD_PASS;
    else if (hazard)                verdict = VD_HOLD;
    else if (mismatch)              verdict = VD_BLOCK;
    else                            verdict = VD_PASS;
  end

  assign fwd_valid = (verdict == VD_PASS);
  assign acc_ready = (verdict == VD_PASS) ? mem_ready : (verdict == VD_BLOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_valid    <= 1'b0;
      fault_addr     <= '0;
      fault_ptr_ver  <= '0;
      fault_line_ver <= '0;
    end else begin
      fault_valid <= (verdict == VD_BLOCK);
      if (verdict == VD_BLOCK) begin
        fault_addr     <= masked;
        fault_ptr_ver  <= ptr_ver;
        fault_line_ver <= line_ver;
      end
    end
  end

  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> $past(req_valid && acc_ready && !fwd_valid)); // R4
  AST_FAULT_VERS_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (fault_ptr_ver != fault_line_ver)); // R4
  AST_BYPASS_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_en) |=> !fault_valid); // R7
  AST_HOLD_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && chk_en && hazard) |-> (!acc_ready && !fwd_valid)); // R6
endmodule

// File: rtl/ptag_guard.sv
module ptag_guard
  import ptag_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int VER_W      = 4,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int NUM_LINES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_ptr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              tagw_valid,
  input  logic [ADDR_W-1:0] tagw_addr,
  input  logic [VER_W-1:0]  tagw_ver,
  output logic              fault_valid,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [VER_W-1:0]  fault_ptr_ver,
  output logic [VER_W-1:0]  fault_line_ver
);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(NUM_LINES);

  logic [VER_W-1:0]  req_ver, tw_ver_unused, line_ver;
  logic [ADDR_W-1:0] req_masked, tw_masked_unused;
  logic [IDX_W-1:0]  req_idx, tw_idx;
  logic              hazard;
  verdict_e          verdict;

  ptag_addr_split #(.ADDR_W(ADDR_W), .VER_W(VER_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_req_split (
    .ptr(req_ptr), .ver(req_ver), .masked(req_masked), .idx(req_idx));

  ptag_addr_split #(.ADDR_W(ADDR_W), .VER_W(VER_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_tw_split (
    .ptr(tagw_addr), .ver(tw_ver_unused), .masked(tw_masked_unused), .idx(tw_idx));

  ptag_store #(.VER_W(VER_W), .NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(tagw_valid), .wr_idx(tw_idx), .wr_ver(tagw_ver),
    .rd_idx(req_idx), .rd_ver(line_ver));

  // same-line tag write wins; the request waits one cycle
  assign hazard = tagw_valid && (tw_idx == req_idx);

  ptag_judge #(.ADDR_W(ADDR_W), .VER_W(VER_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .req_valid(req_valid),
    .mem_ready(mem_ready), .hazard(hazard), .ptr_ver(req_ver), .line_ver(line_ver),
    .masked(req_masked), .verdict(verdict), .fwd_valid(mem_valid), .acc_ready(req_ready),
    .fault_valid(fault_valid), .fault_addr(fault_addr),
    .fault_ptr_ver(fault_ptr_ver), .fault_line_ver(fault_line_ver));

  assign mem_addr  = req_masked;
  assign mem_write = req_write;
  assign mem_wdata = req_wdata;

  AST_MASKED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[ADDR_W-1 -: VER_W] == '0)); // R2
  AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (req_ready == mem_ready)); // R3
  AST_FWD_ONLY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> req_valid); // R3
  AST_NO_FAULT_AFTER_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |=> !fault_valid); // R10
endmodule

// File: tb/ptag_guard_tb_top.sv
module ptag_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_ptr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [63:0] mem_addr;
  logic        mem_write;
  logic [31:0] mem_wdata;
  logic        tagw_valid = 1'b0;
  logic [63:0] tagw_addr = '0;
  logic [3:0]  tagw_ver = '0;
  logic        fault_valid;
  logic [63:0] fault_addr;
  logic [3:0]  fault_ptr_ver, fault_line_ver;

  int n_checks = 0;
  int n_errors = 0;
  logic [3:0] model_ver [16];

  always #4 clk = ~clk; // 125 MHz

  ptag_guard dut_i (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_ptr(req_ptr),
    .req_write(req_write), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_write(mem_write), .mem_wdata(mem_wdata),
    .tagw_valid(tagw_valid), .tagw_addr(tagw_addr), .tagw_ver(tagw_ver),
    .fault_valid(fault_valid), .fault_addr(fault_addr),
    .fault_ptr_ver(fault_ptr_ver), .fault_line_ver(fault_line_ver));

  function automatic logic [63:0] mkptr(input logic [3:0] v, input logic [59:0] a);
    return {v, a};
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; tagw_valid = 1'b0; mem_ready = 1'b1; chk_en = 1'b1;
  endtask

  task automatic tag_write(input logic [63:0] a, input logic [3:0] v);
    tagw_valid = 1'b1; tagw_addr = a; tagw_ver = v;
    model_ver[a[9:6]] = v;
    @(negedge clk);
    tagw_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 fault_valid after reset", {63'd0, fault_valid}, 64'd0);
    req_valid = 1'b1; req_ptr = mkptr(4'h0, 60'h1240); req_write = 1'b1; req_wdata = 32'hA5A5_0011;
    #1;
    chk("R1 version0 forwarded", {63'd0, mem_valid}, 64'd1);
    chk("R2 mem_addr", mem_addr, 64'h1240);
    chk("R2 mem_write", {63'd0, mem_write}, 64'd1);
    chk("R2 mem_wdata", {32'd0, mem_wdata}, 64'hA5A5_0011);
    @(negedge clk); idle();
    chk("R10 no fault after pass", {63'd0, fault_valid}, 64'd0);
  endtask

  task automatic t_mask();
    tag_write(64'h2C0, 4'h5);
    req_valid = 1'b1; req_ptr = mkptr(4'h5, 60'h0AB_CDEF_0000_02C0); req_write = 1'b0;
    #1;
    chk("R5 programmed version passes", {63'd0, mem_valid}, 64'd1);
    chk("R2 version bits cleared", mem_addr, 64'h00AB_CDEF_0000_02C0);
    chk("R2 load flag", {63'd0, mem_write}, 64'd0);
    @(negedge clk); idle();
  endtask

  task automatic t_backpressure();
    req_valid = 1'b1; req_ptr = mkptr(4'h5, 60'h2C8); mem_ready = 1'b0;
    #1;
    chk("R3 mem_valid under stall", {63'd0, mem_valid}, 64'd1);
    chk("R3 req_ready follows low", {63'd0, req_ready}, 64'd0);
    @(negedge clk);
    mem_ready = 1'b1;
    #1;
    chk("R3 req_ready follows high", {63'd0, req_ready}, 64'd1);
    @(negedge clk); idle();
  endtask

  task automatic t_mismatch();
    req_valid = 1'b1; req_ptr = mkptr(4'h3, 60'h7_0000_02D0);
    #1;
    chk("R4 blocked not forwarded", {63'd0, mem_valid}, 64'd0);
    chk("R4 blocked accepted", {63'd0, req_ready}, 64'd1);
    @(negedge clk); idle();
    chk("R4 fault_valid", {63'd0, fault_valid}, 64'd1);
    chk("R4 fault_addr", fault_addr, 64'h7_0000_02D0);
    chk("R4 fault_ptr_ver", {60'd0, fault_ptr_ver}, 64'd3);
    chk("R4 fault_line_ver", {60'd0, fault_line_ver}, {60'd0, model_ver[11]});
    @(negedge clk);
    chk("R10 fault pulse ends", {63'd0, fault_valid}, 64'd0);
  endtask

  task automatic t_collision();
    req_valid = 1'b1; req_ptr = mkptr(4'h9, 60'h1C4);
    tagw_valid = 1'b1; tagw_addr = 64'h1C0; tagw_ver = 4'h9; model_ver[7] = 4'h9;
    #1;
    chk("R6 held mem_valid", {63'd0, mem_valid}, 64'd0);
    chk("R6 held req_ready", {63'd0, req_ready}, 64'd0);
    @(negedge clk);
    tagw_valid = 1'b0;
    chk("R6 no fault while held", {63'd0, fault_valid}, 64'd0);
    #1;
    chk("R6 new version seen", {63'd0, mem_valid}, 64'd1);
    @(negedge clk); idle();
  endtask

  task automatic t_other_line();
    req_valid = 1'b1; req_ptr = mkptr(4'h0, 60'hC0);
    tagw_valid = 1'b1; tagw_addr = 64'h80; tagw_ver = 4'h6; model_ver[2] = 4'h6;
    #1;
    chk("R8 other line not stalled", {63'd0, mem_valid}, 64'd1);
    chk("R8 accepted", {63'd0, req_ready}, 64'd1);
    @(negedge clk);
    tagw_valid = 1'b0; req_ptr = mkptr(4'h6, 60'h88);
    #1;
    chk("R5 line2 new version", {63'd0, mem_valid}, 64'd1);
    @(negedge clk); idle();
  endtask

  task automatic t_offset();
    req_valid = 1'b1; req_ptr = mkptr(4'h5, 60'h2FF);
    #1;
    chk("R9 last byte of line", {63'd0, mem_valid}, 64'd1);
    @(negedge clk);
    req_ptr = mkptr(4'h5, 60'h300);
    #1;
    chk("R9 next line own tag", {63'd0, mem_valid}, 64'd0);
    @(negedge clk); idle();
    chk("R9 next line faults", {63'd0, fault_valid}, 64'd1);
    @(negedge clk);
  endtask

  task automatic t_bypass();
    chk_en = 1'b0; req_valid = 1'b1; req_ptr = mkptr(4'hF, 60'h2C0);
    #1;
    chk("R7 bypass forwards", {63'd0, mem_valid}, 64'd1);
    chk("R7 bypass ready", {63'd0, req_ready}, 64'd1);
    @(negedge clk); idle();
    chk("R7 bypass no fault", {63'd0, fault_valid}, 64'd0);
  endtask

  initial begin
    #200000;
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model_ver[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_backpressure();
    t_mismatch();
    t_collision();
    t_other_line();
    t_offset();
    t_bypass();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule